// File: doc/BRIEF.md
# Eight-Bank Chip-Select Controller

This block sits between a bus master and a set of static-style memories and peripherals. Each incoming address is compared in parallel against eight programmable windows. The window that claims the address gets its chip-select. The controller then holds the access open for that window's programmed number of wait states and finally returns a one-cycle acknowledge. During the access it drives four active-low byte write strobes and one active-low output enable. The strobes are limited to the byte lanes that the window's port width can carry.

Each window is described by four settings: a base, a compare mask, a wait count and a port width. Windows can also be enabled or disabled and marked read-only. The mask compares address bits 27 down to 15 selectively, and bits 31 to 28 are always compared, so a window spans from 32 KB up to 256 MB. Window 0 is live straight out of reset, which makes it usable for booting. It covers the lowest 256 MB with the slowest timing, and its port width is taken from a strap input during reset.

An address that no window claims, or a write aimed at a read-only window, gets a transfer-error pulse instead of an acknowledge. Nothing is driven to the memories in that case.

Top module: `bank_select_ctrl`

## Requirements
- R1: A window claims an address when it is enabled and address bits [31:28] equal its base bits [16:13], and every address bit [27:15] whose `cfg_mask` bit is 1 (mask bit i pairs with address bit i+15) equals the matching base bit. `cfg_base` holds address bits [31:15].
- R2: When several windows claim an address, the lowest-numbered one is used.
- R3: Wait counts 0 to 30 are honoured, and a programmed value above 30 acts as 30. The acknowledge is high for exactly one cycle, N+2 cycles after the accepting clock edge, where N is the wait count.
- R4: `cs_n` (bit i for window i, active low) has at most one bit low. It is low from the cycle after acceptance through the acknowledge cycle, and all ones in the cycle after.
- R5: For a write, `we_n[i]` is low during the chip-select cycles exactly when `req_be[i]` is set and lane i is carried by the port width. Width code 0 is 8-bit (lane 0 only), 1 is 16-bit (lanes 0 and 1), and 2 or 3 is 32-bit (all lanes).
- R6: `oe_n` is low during the chip-select cycles of a read, and high for writes. It is never low while any `we_n` bit is low.
- R7: A write to a window marked write-protected (`cfg_wp`=1) gives a one-cycle `terr` in the cycle after acceptance, with no chip-select and no strobes. Reads of such a window complete normally.
- R8: An address claimed by no window gives the same one-cycle `terr` with no chip-select and no strobes.
- R9: After reset, window 0 is enabled with base 0 and mask 0 (covering 0x0000_0000 to 0x0FFF_FFFF), 30 wait states, no write protection, and the port width sampled from `boot_width` during reset. All other windows are disabled.
- R10: A request presented while an access is in progress is ignored.
- R11: During and straight after reset, `cs_n` and `we_n` are all ones, `oe_n` is 1, and `ack` and `terr` are 0.
- R12: A window whose `cfg_en` was written as 0 claims no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_width | input | 2 | Strap: port width code of window 0, sampled in reset |
| cfg_we | input | 1 | Write the settings below into window `cfg_sel` |
| cfg_sel | input | 3 | Window number being configured |
| cfg_en | input | 1 | Window enable |
| cfg_base | input | 17 | Base, address bits [31:15] |
| cfg_mask | input | 13 | Compare mask for address bits [27:15] |
| cfg_wait | input | 5 | Wait-state count (clamped to 30) |
| cfg_width | input | 2 | Port width code |
| cfg_wp | input | 1 | Write protection |
| req_valid | input | 1 | Access request, taken when idle |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte lanes requested |
| cs_n | output | 8 | Active-low chip-selects |
| we_n | output | 4 | Active-low byte write strobes |
| oe_n | output | 1 | Active-low output enable |
| ack | output | 1 | Access complete |
| terr | output | 1 | Access refused |

## Verification
The checker watches the shape of every access on every cycle. It confirms that at most one chip-select is active, that read and write strobes never overlap, and that a refused access drives no memory pins. It also confirms that the acknowledge is a single pulse taken while a chip-select is held and followed by its release, and that no chip-select stays low longer than the largest wait count allows. Which window wins a given address, the exact cycle of the acknowledge for each programmed wait count, the lane masking per port width, the strap-selected boot width and the rejection of protected writes depend on the programmed values. Only the bench's scenarios can show these, by comparing against values worked out from the requirements.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  parameter int AW       = 32;  // address width
  parameter int NBANK    = 8;   // number of windows
  parameter int LO_BIT   = 15;  // log2 of smallest window (32 KB)
  parameter int HI_BIT   = 28;  // log2 of largest window (256 MB)
  parameter int WAIT_W   = 5;   // wait counter width
  parameter int MAX_WAIT = 30;  // largest honoured wait count
  parameter int NLANE    = 4;   // byte lanes

  localparam int BASE_W = AW - LO_BIT;
  localparam int MASK_W = HI_BIT - LO_BIT;
  localparam int FIX_W  = AW - HI_BIT;
  localparam int SEL_W  = $clog2(NBANK);

  localparam logic [1:0] PW_8  = 2'd0;
  localparam logic [1:0] PW_16 = 2'd1;
  localparam logic [1:0] PW_32 = 2'd2;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [MASK_W-1:0] mask;
    logic [WAIT_W-1:0] wstates;
    logic [1:0]        width;
    logic              wp;
  } bank_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_ERR} st_e;

  function automatic logic [NLANE-1:0] lane_mask(input logic [1:0] w);
    case (w)
      PW_8:    return NLANE'(1);
      PW_16:   return NLANE'(3);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/bsc_bank_regs.sv
module bsc_bank_regs
  import bsc_pkg::*;
#(
  parameter int BOOT_WAIT = MAX_WAIT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               boot_width,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic                     cfg_en,
  input  logic [BASE_W-1:0]        cfg_base,
  input  logic [MASK_W-1:0]        cfg_mask,
  input  logic [WAIT_W-1:0]        cfg_wait,
  input  logic [1:0]               cfg_width,
  input  logic                     cfg_wp,
  output bank_cfg_t [NBANK-1:0]    cfg_o
);
  localparam int BOOT_N = (BOOT_WAIT > MAX_WAIT) ? MAX_WAIT : BOOT_WAIT;

  logic [WAIT_W-1:0] wait_clamped;
  assign wait_clamped = (cfg_wait > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : cfg_wait;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    bank_cfg_t rst_val;
    if (g == 0) begin : g_boot
      assign rst_val = '{en: 1'b1, base: '0, mask: '0,
                         wstates: WAIT_W'(BOOT_N), width: boot_width, wp: 1'b0};
    end else begin : g_plain
      assign rst_val = '{en: 1'b0, base: '0, mask: '0,
                         wstates: '0, width: PW_32, wp: 1'b0};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[g] <= rst_val;
      end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
        cfg_o[g] <= '{en: cfg_en, base: cfg_base, mask: cfg_mask,
                      wstates: wait_clamped, width: cfg_width, wp: cfg_wp};
      end
    end
  end
endmodule

// File: rtl/bsc_bank_match.sv
module bsc_bank_match
  import bsc_pkg::*;
(
  input  bank_cfg_t         cfg_i,
  input  logic [AW-1:0]     addr_i,
  output logic              hit_o
);
  logic [AW-1:0] base_full;
  logic [AW-1:0] cmp_mask;

  assign base_full = {cfg_i.base, {LO_BIT{1'b0}}};
  assign cmp_mask  = {{FIX_W{1'b1}}, cfg_i.mask, {LO_BIT{1'b0}}};
  assign hit_o     = cfg_i.en && (((addr_i ^ base_full) & cmp_mask) == '0);
endmodule

// File: rtl/bsc_prio.sv
module bsc_prio
  import bsc_pkg::*;
(
  input  logic [NBANK-1:0] hit_i,
  output logic             found_o,
  output logic [SEL_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/bank_select_ctrl.sv
module bank_select_ctrl
  import bsc_pkg::*;
#(
  parameter int BOOT_WAIT = MAX_WAIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        boot_width,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic              cfg_en,
  input  logic [16:0]       cfg_base,
  input  logic [12:0]       cfg_mask,
  input  logic [4:0]        cfg_wait,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_wp,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic [3:0]        req_be,
  output logic [7:0]        cs_n,
  output logic [3:0]        we_n,
  output logic              oe_n,
  output logic              ack,
  output logic              terr
);
  bank_cfg_t [NBANK-1:0] cfg;
  logic [NBANK-1:0]      hit;
  logic                  found;
  logic [SEL_W-1:0]      pick;

  bsc_bank_regs #(.BOOT_WAIT(BOOT_WAIT)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .boot_width (boot_width),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_en     (cfg_en),
    .cfg_base   (cfg_base),
    .cfg_mask   (cfg_mask),
    .cfg_wait   (cfg_wait),
    .cfg_width  (cfg_width),
    .cfg_wp     (cfg_wp),
    .cfg_o      (cfg)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_match
    bsc_bank_match u_match (
      .cfg_i  (cfg[g]),
      .addr_i (req_addr),
      .hit_o  (hit[g])
    );
  end

  bsc_prio u_prio (
    .hit_i   (hit),
    .found_o (found),
    .idx_o   (pick)
  );

  st_e               st_q, st_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [NLANE-1:0]  lanes_q, lanes_d;
  logic              blocked;
  logic              sel_on;

  assign blocked = req_write && cfg[pick].wp;

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    lanes_d = lanes_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (found && !blocked) begin
            st_d    = ST_WAIT;
            sel_d   = pick;
            cnt_d   = cfg[pick].wstates;
            wr_d    = req_write;
            lanes_d = req_be & lane_mask(cfg[pick].width);
          end else begin
            st_d = ST_ERR;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) st_d = ST_ACK;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign sel_on = (st_d == ST_WAIT) || (st_d == ST_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      lanes_q <= '0;
      cs_n    <= '1;
      we_n    <= '1;
      oe_n    <= 1'b1;
      ack     <= 1'b0;
      terr    <= 1'b0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      lanes_q <= lanes_d;
      cs_n    <= sel_on ? ~(NBANK'(1) << sel_d) : '1;
      we_n    <= (sel_on && wr_d) ? ~lanes_d : '1;
      oe_n    <= !(sel_on && !wr_d);
      ack     <= (st_d == ST_ACK);
      terr    <= (st_d == ST_ERR);
    end
  end
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk
  import bsc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NBANK-1:0] cs_n,
  input logic [NLANE-1:0] we_n,
  input logic             oe_n,
  input logic             ack,
  input logic             terr
);
  logic [7:0] held;

  always_ff @(posedge clk) begin
    if (rst || (cs_n == '1)) held <= '0;
    else if (held != 8'hFF)  held <= held + 1'b1;
  end

  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (we_n != '1) |-> oe_n);

  // R7 R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    terr |-> ((cs_n == '1) && (we_n == '1) && oe_n && !ack));

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R4
  ack_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cs_n != '1));

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> (cs_n == '1));

  // R3
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> (held < 8'(MAX_WAIT + 2)));
endmodule

bind bank_select_ctrl bsc_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .cs_n (cs_n),
  .we_n (we_n),
  .oe_n (oe_n),
  .ack  (ack),
  .terr (terr)
);

// File: tb/test_bank_select_ctrl.sv
module test_bank_select_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  boot_width = 2'd2;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic        cfg_en = 1'b0;
  logic [16:0] cfg_base = '0;
  logic [12:0] cfg_mask = '0;
  logic [4:0]  cfg_wait = '0;
  logic [1:0]  cfg_width = '0;
  logic        cfg_wp = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_be = '0;
  logic [7:0]  cs_n;
  logic [3:0]  we_n;
  logic        oe_n;
  logic        ack;
  logic        terr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bank_select_ctrl i_bank_select_ctrl (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [3:0]  be;
    logic [3:0]  bank;  // 8 = refused
    logic [5:0]  k;     // negedges from acceptance to ack/terr
    logic [3:0]  we;
    logic        oe;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0000, 1'b0, 4'hF, 4'd1, 6'd2,  4'hF, 1'b0},  // R1 32 KB window, 0 waits
    '{32'h1000_7FFC, 1'b1, 4'hF, 4'd1, 6'd2,  4'h0, 1'b1},  // R1 top of 32 KB window
    '{32'h1000_8000, 1'b0, 4'hF, 4'd8, 6'd1,  4'hF, 1'b1},  // R8 just past window
    '{32'h2345_6780, 1'b1, 4'h6, 4'd2, 6'd4,  4'hD, 1'b1},  // R2 R5 overlap, 16-bit
    '{32'h3000_0010, 1'b0, 4'hF, 4'd3, 6'd7,  4'hF, 1'b0},  // R7 read of protected ok
    '{32'h3000_0010, 1'b1, 4'hF, 4'd8, 6'd1,  4'hF, 1'b1},  // R7 protected write refused
    '{32'h3800_0000, 1'b1, 4'hF, 4'd4, 6'd3,  4'hC, 1'b1},  // R1 R5 bit 27 set
    '{32'h3800_0000, 1'b0, 4'hF, 4'd4, 6'd3,  4'hF, 1'b0},  // R6 read
    '{32'hF123_4560, 1'b1, 4'hA, 4'd7, 6'd5,  4'h5, 1'b1},  // R5 32-bit lanes
    '{32'h0000_0100, 1'b1, 4'hF, 4'd0, 6'd32, 4'h0, 1'b1},  // R9 boot window
    '{32'h4000_0000, 1'b0, 4'hF, 4'd8, 6'd1,  4'hF, 1'b1},  // R8 no window
    '{32'h37FF_FFFC, 1'b0, 4'h3, 4'd3, 6'd7,  4'hF, 1'b0}   // R2 lower window wins
  };

  task automatic chk(input string rid, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rid, act, exp);
    end
  endtask

  task automatic cfg_bank(input int b, input logic en, input logic [16:0] base,
                          input logic [12:0] mask, input logic [4:0] w,
                          input logic [1:0] wd, input logic wp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(b); cfg_en = en; cfg_base = base;
    cfg_mask = mask; cfg_wait = w; cfg_width = wd; cfg_wp = wp;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [3:0] b,
                      output int k, output logic [7:0] cs1, output logic [3:0] we1,
                      output logic oe1, output logic got_err, output logic [7:0] cs_after);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_be = b;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; cs1 = cs_n; we1 = we_n; oe1 = oe_n;
    while (!(ack || terr) && k < 100) begin
      @(negedge clk);
      k++;
    end
    got_err = terr;
    @(negedge clk);
    cs_after = cs_n;
  endtask

  task automatic do_reset(input logic [1:0] strap);
    @(negedge clk);
    rst = 1'b1; boot_width = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    logic [7:0] cs1, csa;
    logic [3:0] we1;
    logic oe1, ge;

    // R11 outputs idle during reset
    repeat (2) @(negedge clk);
    chk("R11 cs_n", 64'(cs_n), 64'hFF);
    chk("R11 we_n", 64'(we_n), 64'hF);
    chk("R11 oe_n/ack/terr", 64'({oe_n, ack, terr}), 64'b100);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", 64'({cs_n, we_n, oe_n, ack, terr}), 64'({8'hFF, 4'hF, 3'b100}));

    cfg_bank(1, 1'b1, 17'h02000, 13'h1FFF, 5'd0, 2'd2, 1'b0);
    cfg_bank(2, 1'b1, 17'h04000, 13'h0000, 5'd2, 2'd1, 1'b0);
    cfg_bank(5, 1'b1, 17'h04000, 13'h0000, 5'd7, 2'd2, 1'b0);
    cfg_bank(3, 1'b1, 17'h06000, 13'h1000, 5'd5, 2'd0, 1'b1);
    cfg_bank(4, 1'b1, 17'h07000, 13'h0000, 5'd1, 2'd1, 1'b0);
    cfg_bank(7, 1'b1, 17'h1E000, 13'h0000, 5'd3, 2'd3, 1'b0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [7:0] ecs;
      t = VECS[v];
      ecs = (t.bank == 4'd8) ? 8'hFF : ~(8'd1 << t.bank);
      xfer(t.addr, t.wr, t.be, k, cs1, we1, oe1, ge, csa);
      chk("R1 R2 R4 cs_n", 64'(cs1), 64'(ecs));
      chk("R3 R7 R8 cycles", 64'(k), 64'(t.k));
      chk("R7 R8 terr", 64'(ge), 64'(t.bank == 4'd8));
      chk("R5 we_n", 64'(we1), 64'(t.we));
      chk("R6 oe_n", 64'(oe1), 64'(t.oe));
      chk("R4 cs released", 64'(csa), 64'hFF);
    end

    // R3 clamp: 31 acts as 30
    cfg_bank(1, 1'b1, 17'h02000, 13'h1FFF, 5'd31, 2'd2, 1'b0);
    xfer(32'h1000_0040, 1'b0, 4'hF, k, cs1, we1, oe1, ge, csa);
    chk("R3 clamp cycles", 64'(k), 64'd32);
    chk("R3 clamp cs", 64'(cs1), 64'hFD);

    // R12 disabled window claims nothing
    cfg_bank(1, 1'b0, 17'h02000, 13'h1FFF, 5'd0, 2'd2, 1'b0);
    xfer(32'h1000_0040, 1'b0, 4'hF, k, cs1, we1, oe1, ge, csa);
    chk("R12 disabled terr", 64'(ge), 64'd1);
    chk("R12 disabled cs", 64'(cs1), 64'hFF);

    // R10 request during access ignored
    cfg_bank(1, 1'b1, 17'h02000, 13'h1FFF, 5'd0, 2'd2, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2000_0000; req_write = 1'b0; req_be = 4'hF;
    @(negedge clk);
    req_addr = 32'h1000_0000;  // still valid: must be ignored
    k = 1;
    @(negedge clk);
    k++;
    chk("R10 cs held on window 2", 64'(cs_n), 64'hFB);
    req_valid = 1'b0;
    while (!(ack || terr) && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R10 cycles", 64'(k), 64'd4);
    @(negedge clk);
    chk("R10 no second access", 64'(cs_n), 64'hFF);
    @(negedge clk);
    chk("R10 still idle", 64'({cs_n, ack, terr}), 64'({8'hFF, 2'b00}));

    // R9 boot strap 8-bit, other windows cleared
    do_reset(2'd0);
    xfer(32'h0000_0100, 1'b1, 4'hF, k, cs1, we1, oe1, ge, csa);
    chk("R9 8-bit boot we_n", 64'(we1), 64'hE);
    chk("R9 boot cycles", 64'(k), 64'd32);
    xfer(32'h1000_0000, 1'b0, 4'hF, k, cs1, we1, oe1, ge, csa);
    chk("R9 window 1 off after reset", 64'(ge), 64'd1);

    // R9 boot strap 16-bit
    do_reset(2'd1);
    xfer(32'h0800_0000, 1'b1, 4'hF, k, cs1, we1, oe1, ge, csa);
    chk("R9 16-bit boot we_n", 64'(we1), 64'hC);
    chk("R9 boot cs", 64'(cs1), 64'hFE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule